// File: doc/BRIEF.md
# Tiled single-port RAM

A synchronous single-port memory assembled from identical small storage tiles. Tiles are stacked in depth to reach the requested word count and placed side by side to reach the requested word width. Every tile latches the address, write data and write enable on the rising clock edge before it touches its array. Every tile also has a read register that can be followed by an optional output register. A 3-bit chip-select taken from the upper address bits picks one tile in a group of eight. When more than eight tiles are stacked, a group decode above the chip-select picks the group.

The user sees one flat memory, with clock, clock enable, write enable, reset, address, write data and read data. Reset is synchronous and clears only the pipeline registers, so stored words survive it. A write also returns its own data on the read port, with the same latency as a read.

Top module: `tiled_sp_ram`

## Requirements
- R1: `addr`, `din` and `we` are sampled on the rising clock edge where `ce` is high. Later changes to these inputs do not alter the access already sampled.
- R2: With `OUT_REG`=0, read data appears on `dout` after the second rising edge that follows the sampling edge's setup, which is one cycle after the address is registered. With `OUT_REG`=1 it appears one cycle later.
- R3: While `rst` is high at a rising edge, the input, read and output registers are cleared, whatever `ce` is. `dout` then reads zero.
- R4: Address bits [log2(TILE_DEPTH)-1:0] select the word inside a tile. The next three bits are the chip-select within a group of eight tiles, and any higher bits pick the group. Each access enables at most one row of tiles.
- R5: Every bit of a `WIDTH`-bit word is stored and returned independently across the side-by-side tiles.
- R6: While `ce` is low, `dout` holds its value and no word is written, even with `we` high.
- R7: A write returns the newly written word on `dout`, with the same latency as a read.
- R8: A read returns the word most recently written to that address.
- R9: Reset leaves stored words unchanged. A write sampled before reset but not yet performed is discarded.
- R10: Reads issued on consecutive cycles, across tile and group boundaries, each return their own word. This relies on the output select being delayed to match the read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Clock enable, active high |
| we | input | 1 | Write enable, active high |
| rst | input | 1 | Synchronous reset of pipeline registers, active high |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |

## Verification
The bench builds two copies with 4-word, 2-bit tiles, a 64-word depth and a 4-bit width, one with the output register and one without. Sixteen tile rows make two chip-select groups, so both the in-group chip-select match and the group decode above it are exercised. Two columns are used for the width split. At this size every address can be written and read back under two data patterns, and a streamed read can run across all tile and group edges.

// File: rtl/tiled_sp_ram.sv
module tiled_sp_ram #(
  parameter int TILE_DEPTH = 16,
  parameter int TILE_W     = 4,
  parameter int DEPTH      = 256,
  parameter int WIDTH      = 8,
  parameter int OUT_REG    = 1,
  localparam int NR  = DEPTH / TILE_DEPTH,
  localparam int NC  = WIDTH / TILE_W,
  localparam int NG  = (NR + 7) / 8,
  localparam int LAW = $clog2(TILE_DEPTH),
  localparam int UW  = (NR > 1) ? $clog2(NR) : 1,
  localparam int XW  = LAW + UW,
  localparam int AW  = LAW + ((NR > 1) ? $clog2(NR) : 0)
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             we,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [XW-1:0]    a_q;
  logic [WIDTH-1:0] d_q;
  logic             w_q;
  logic [UW-1:0]    sel_q;
  logic [NR-1:0]    tile_en;
  logic [NG-1:0]    grp_en;
  logic [NR-1:0][WIDTH-1:0] row_rd;
  logic [WIDTH-1:0] mux_rd;

  wire [UW-1:0]  row = a_q[XW-1:LAW];
  wire [2:0]     cs  = 3'(row);
  wire [LAW-1:0] lo  = a_q[LAW-1:0];

  always_ff @(posedge clk)
    if (rst) begin
      a_q   <= '0;
      d_q   <= '0;
      w_q   <= 1'b0;
      sel_q <= '0;
    end else if (ce) begin
      a_q   <= XW'(addr);
      d_q   <= din;
      w_q   <= we;
      sel_q <= row;
    end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_en[g] = (row >> 3) == UW'(g);
  end

  for (genvar r = 0; r < NR; r++) begin : g_row
    assign tile_en[r] = grp_en[r/8] && (cs == 3'(r));
    for (genvar c = 0; c < NC; c++) begin : g_col
      logic [TILE_W-1:0] mem [TILE_DEPTH];
      logic [TILE_W-1:0] rd;
      always_ff @(posedge clk)
        if (rst) rd <= '0;
        else if (ce && tile_en[r]) begin
          if (w_q) begin
            mem[lo] <= d_q[c*TILE_W +: TILE_W];
            rd      <= d_q[c*TILE_W +: TILE_W];
          end else begin
            rd <= mem[lo];
          end
        end
      assign row_rd[r][c*TILE_W +: TILE_W] = rd;
    end
  end

  assign mux_rd = row_rd[sel_q];

  if (OUT_REG != 0) begin : g_oreg
    logic [WIDTH-1:0] o_q;
    always_ff @(posedge clk)
      if (rst)     o_q <= '0;
      else if (ce) o_q <= mux_rd;
    assign dout = o_q;
  end else begin : g_noreg
    assign dout = mux_rd;
  end

endmodule

module tiled_sp_ram_chk #(
  parameter int OUT_REG = 1,
  parameter int DEPTH   = 256,
  parameter int NR      = 16,
  parameter int WIDTH   = 8,
  parameter int AW      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             we,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic [NR-1:0]    tile_en
);

  a_r4_single_tile: assert property (@(posedge clk) disable iff (rst)
    ce |-> $countones(tile_en) <= 1);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(dout));

  if (OUT_REG != 0) begin : g_o
    a_r7_write_through: assert property (@(posedge clk) disable iff (rst)
      (ce && we && int'(addr) < DEPTH) ##1 ce ##1 ce |=> dout == $past(din, 3));
    a_r8_store_and_read: assert property (@(posedge clk) disable iff (rst)
      (ce && we && int'(addr) < DEPTH) ##1 (ce && !we && addr == $past(addr))
        ##1 ce ##1 ce |=> dout == $past(din, 4));
  end else begin : g_n
    a_r7_write_through: assert property (@(posedge clk) disable iff (rst)
      (ce && we && int'(addr) < DEPTH) ##1 ce |=> dout == $past(din, 2));
    a_r8_store_and_read: assert property (@(posedge clk) disable iff (rst)
      (ce && we && int'(addr) < DEPTH) ##1 (ce && !we && addr == $past(addr))
        ##1 ce |=> dout == $past(din, 3));
  end

endmodule

bind tiled_sp_ram tiled_sp_ram_chk #(
  .OUT_REG(OUT_REG), .DEPTH(DEPTH), .NR(NR), .WIDTH(WIDTH), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr),
  .din(din), .dout(dout), .tile_en(tile_en)
);

// File: tb/tiled_sp_ram_tb.sv
`timescale 1ns/1ps
module tiled_sp_ram_tb;
  localparam int TD = 4, TW = 2, DP = 64, WD = 4, AW = 6;

  logic clk = 1'b0, ce = 1'b0, we = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [WD-1:0] din = '0;
  logic [WD-1:0] dout_r, dout_n;
  logic [WD-1:0] model [DP];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  tiled_sp_ram #(.TILE_DEPTH(TD), .TILE_W(TW), .DEPTH(DP), .WIDTH(WD), .OUT_REG(1)) u_dut (
    .clk(clk), .ce(ce), .we(we), .rst(rst), .addr(addr), .din(din), .dout(dout_r));
  tiled_sp_ram #(.TILE_DEPTH(TD), .TILE_W(TW), .DEPTH(DP), .WIDTH(WD), .OUT_REG(0)) u_dut_nr (
    .clk(clk), .ce(ce), .we(we), .rst(rst), .addr(addr), .din(din), .dout(dout_n));

  task automatic chk(input string req, input logic [WD-1:0] act, input logic [WD-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic op(input int a, input bit wr, input logic [WD-1:0] d, input string req);
    logic [WD-1:0] exp;
    @(negedge clk);
    ce = 1'b1; we = wr; addr = AW'(a); din = d;
    if (wr) model[a] = d;
    exp = model[a];
    @(negedge clk);
    we = 1'b0;
    @(negedge clk);
    chk({req, " no-oreg"}, dout_n, exp);
    @(negedge clk);
    chk({req, " oreg"}, dout_r, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [WD-1:0] hr, hn;
    repeat (3) @(negedge clk);
    chk("R3 reset dout oreg", dout_r, '0);
    chk("R3 reset dout no-oreg", dout_n, '0);
    rst = 1'b0;

    for (int a = 0; a < DP; a++) op(a, 1'b1, WD'(a * 7 + 3), "R7 write-through");
    for (int a = 0; a < DP; a++) op(a, 1'b0, '0, "R8 R4 readback p1");
    for (int a = DP - 1; a >= 0; a--) op(a, 1'b1, ~WD'(a * 5 + 1), "R7 R5 write p2");
    for (int a = 0; a < DP; a++) op(a, 1'b0, '0, "R8 R5 readback p2");

    // R6 stall: read of 5 is sampled, then ce drops with a write pending at the pins
    @(negedge clk);
    hr = dout_r; hn = dout_n;
    ce = 1'b1; we = 1'b0; addr = AW'(5);
    @(negedge clk);
    ce = 1'b0; we = 1'b1; addr = AW'(9); din = ~model[9];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 hold oreg", dout_r, hr);
      chk("R6 hold no-oreg", dout_n, hn);
    end
    ce = 1'b1; we = 1'b0; addr = AW'(5);
    @(negedge clk);
    chk("R6 R2 resume no-oreg", dout_n, model[5]);
    @(negedge clk);
    chk("R6 R2 resume oreg", dout_r, model[5]);
    op(9, 1'b0, '0, "R6 no write while ce low");

    // R9 reset mid-stream with a sampled write pending
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = AW'(20); din = ~model[20];
    @(negedge clk);
    we = 1'b0; rst = 1'b1; ce = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R3 mid reset oreg", dout_r, '0);
    chk("R3 mid reset no-oreg", dout_n, '0);
    rst = 1'b0;
    for (int a = 0; a < DP; a++) op(a, 1'b0, '0, "R9 contents kept");

    // R10 R1 streamed reads, one new address each cycle
    @(negedge clk);
    ce = 1'b1; we = 1'b0;
    for (int k = 0; k < DP + 3; k++) begin
      if (k >= 2 && k - 2 < DP) chk("R10 R1 stream no-oreg", dout_n, model[k-2]);
      if (k >= 3 && k - 3 < DP) chk("R10 R2 stream oreg", dout_r, model[k-3]);
      addr = AW'((k < DP) ? k : 0);
      din = WD'(k);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule